// File: doc/BRIEF.md
# Digital PLL Operating Mode Controller

This block decides how a digital phase-locked loop runs at any moment. Monitor logic outside it flags each timing reference as usable or not. A phase detector reports whether the loop is in phase. The loop filter supplies its present frequency control word. From these inputs the controller steps through four modes: free-running, acquiring lock, locked, and holdover. It also chooses which reference the loop follows and which frequency word drives the oscillator.

While the loop is locked, the controller keeps a smoothed history of the loop's frequency word. When every reference is lost, that history holds the oscillator steady. A manual override can put the controller into any mode for bring-up or test. Automatic sequencing resumes from that mode once the override is released.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after reset, `mode` is free-run (encoding 0), `ref_sel` is 0 and `freq_out` equals the nominal word (`NOMINAL`, default 16'h8000).
- R2: In free-run with no override, if any bit of `ref_qual` is set, then on the next clock edge `mode` becomes lock acquisition (encoding 1).
- R3: Whenever a new reference is chosen, `ref_sel` takes the lowest index among the set bits of `ref_qual`.
- R4: In lock acquisition, `mode` becomes locked (encoding 2) on the clock edge after `phase_lock` has been high for `LOCK_CYCLES` consecutive cycles while the selected reference stayed qualified. A low cycle restarts the count.
- R5: In lock acquisition or locked mode, if the selected reference loses qualification while another is still qualified, `ref_sel` moves to the lowest qualified index and `mode` is, or stays, lock acquisition with the lock count restarted.
- R6: In lock acquisition or locked mode, if no reference is qualified, `mode` becomes holdover (encoding 3) when the history is valid and free-run otherwise.
- R7: In holdover with no override, if any reference becomes qualified, `mode` returns to lock acquisition on the next edge.
- R8: The history updates only in locked mode. Its first sample loads the loop word directly. Each later sample computes h + ((x - h) >>> `AVG_SHIFT`), with a signed difference and an arithmetic shift. The history counts as valid once `HIST_MIN` samples have been taken.
- R9: `freq_out` depends on the mode:
  - free-run: the nominal word.
  - lock acquisition and locked: the live `loop_freq`.
  - holdover: the held history, or the nominal word if no valid history exists.
- R10: While `force_en` is high, the next `mode` equals `force_mode`, using the encodings above. `ref_sel` moves to the lowest qualified index if any reference is qualified, and is held otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_qual | input | NUM_REFS | Per-reference qualified flags from the monitors |
| phase_lock | input | 1 | Raw phase-lock indication from the phase detector |
| loop_freq | input | FW | Current frequency word of the loop filter |
| force_en | input | 1 | Manual mode override enable |
| force_mode | input | 2 | Mode to force while the override is active |
| mode | output | 2 | Current operating mode |
| ref_sel | output | $clog2(NUM_REFS) | Index of the reference the loop follows |
| freq_out | output | FW | Frequency word for the oscillator |

## Verification
The properties assume that `ref_qual`, `phase_lock` and the override inputs change only between clock edges and hold defined values from reset onward. They also assume that `LOCK_CYCLES` is at least one, so a lock decision always follows at least one observed high `phase_lock`. The stimulus keeps to these assumptions by driving every input on the falling edge. Qualification flags change only occasionally, so lock, switchover and holdover paths all get exercised, and overrides are inserted at random as short bursts. Directed phases reach the paths that random stimulus seldom hits:
- loss of all references before the history is valid;
- a lock run interrupted by one low cycle.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;
    typedef enum logic [1:0] {
        MODE_FREE   = 2'd0,
        MODE_ACQ    = 2'd1,
        MODE_NORMAL = 2'd2,
        MODE_HOLD   = 2'd3
    } mode_e;
endpackage

// File: rtl/dpll_ref_pick.sv
module dpll_ref_pick #(
    parameter int NUM_REFS = 4,
    parameter int RW       = $clog2(NUM_REFS)
) (
    input  logic [NUM_REFS-1:0] qual,
    output logic                any_qual,
    output logic [RW-1:0]       low_idx
);
    // Priority encoder: lowest set index wins
    always_comb begin
        low_idx = '0;
        for (int i = NUM_REFS - 1; i >= 0; i--) begin
            if (qual[i]) low_idx = RW'(i);
        end
    end

    assign any_qual = |qual;
endmodule

// File: rtl/dpll_lock_filter.sv
module dpll_lock_filter #(
    parameter int LOCK_CYCLES = 8,
    parameter int CW          = $clog2(LOCK_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic count_en,
    input  logic lock_in,
    output logic locked
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (count_en && lock_in) begin
            cnt_d = (cnt_q == CW'(LOCK_CYCLES)) ? cnt_q : cnt_q + CW'(1);
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign locked = (cnt_q == CW'(LOCK_CYCLES));
endmodule

// File: rtl/dpll_freq_history.sv
module dpll_freq_history #(
    parameter int          FW        = 16,
    parameter int          AVG_SHIFT = 2,
    parameter int          HIST_MIN  = 8,
    parameter logic [FW-1:0] NOMINAL = {1'b1, {(FW-1){1'b0}}},
    parameter int          CW        = $clog2(HIST_MIN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_en,
    input  logic [FW-1:0] freq_in,
    output logic [FW-1:0] hist_freq,
    output logic          hist_valid
);
    logic [FW-1:0]        hist_d, hist_q;
    logic [CW-1:0]        cnt_d, cnt_q;
    logic signed [FW:0]   diff, step, sum;

    always_comb begin
        diff   = $signed({1'b0, freq_in}) - $signed({1'b0, hist_q});
        step   = diff >>> AVG_SHIFT;
        sum    = $signed({1'b0, hist_q}) + step;
        hist_d = hist_q;
        cnt_d  = cnt_q;
        if (sample_en) begin
            hist_d = (cnt_q == '0) ? freq_in : sum[FW-1:0];
            if (cnt_q != CW'(HIST_MIN)) cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= NOMINAL;
            cnt_q  <= '0;
        end else begin
            hist_q <= hist_d;
            cnt_q  <= cnt_d;
        end
    end

    assign hist_freq  = hist_q;
    assign hist_valid = (cnt_q == CW'(HIST_MIN));
endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
    import dpll_mode_pkg::*;
#(
    parameter int            NUM_REFS    = 4,
    parameter int            FW          = 16,
    parameter int            LOCK_CYCLES = 8,
    parameter int            AVG_SHIFT   = 2,
    parameter int            HIST_MIN    = 8,
    parameter logic [FW-1:0] NOMINAL     = {1'b1, {(FW-1){1'b0}}},
    parameter int            RW          = $clog2(NUM_REFS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_REFS-1:0] ref_qual,
    input  logic                phase_lock,
    input  logic [FW-1:0]       loop_freq,
    input  logic                force_en,
    input  logic [1:0]          force_mode,
    output logic [1:0]          mode,
    output logic [RW-1:0]       ref_sel,
    output logic [FW-1:0]       freq_out
);
    typedef struct packed {
        mode_e         mode;
        logic [RW-1:0] ref_sel;
    } ctrl_t;

    ctrl_t          st_d, st_q;
    logic           any_qual, sel_ok, locked, hist_valid;
    logic [RW-1:0]  low_idx;
    logic [FW-1:0]  hist_freq;
    mode_e          fallback;

    dpll_ref_pick #(.NUM_REFS(NUM_REFS), .RW(RW)) u_pick (
        .qual     (ref_qual),
        .any_qual (any_qual),
        .low_idx  (low_idx)
    );

    assign sel_ok = ref_qual[st_q.ref_sel];

    dpll_lock_filter #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en ((st_q.mode == MODE_ACQ) && sel_ok),
        .lock_in  (phase_lock),
        .locked   (locked)
    );

    dpll_freq_history #(
        .FW(FW), .AVG_SHIFT(AVG_SHIFT), .HIST_MIN(HIST_MIN), .NOMINAL(NOMINAL)
    ) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_en  (st_q.mode == MODE_NORMAL),
        .freq_in    (loop_freq),
        .hist_freq  (hist_freq),
        .hist_valid (hist_valid)
    );

    assign fallback = hist_valid ? MODE_HOLD : MODE_FREE;

    always_comb begin
        st_d = st_q;
        if (force_en) begin
            st_d.mode = mode_e'(force_mode);
            if (any_qual) st_d.ref_sel = low_idx;
        end else begin
            unique case (st_q.mode)
                MODE_FREE, MODE_HOLD: begin
                    if (any_qual) begin
                        st_d.mode    = MODE_ACQ;
                        st_d.ref_sel = low_idx;
                    end
                end
                MODE_ACQ: begin
                    if (!any_qual)    st_d.mode    = fallback;
                    else if (!sel_ok) st_d.ref_sel = low_idx;
                    else if (locked)  st_d.mode    = MODE_NORMAL;
                end
                MODE_NORMAL: begin
                    if (!sel_ok) begin
                        if (any_qual) begin
                            st_d.mode    = MODE_ACQ;
                            st_d.ref_sel = low_idx;
                        end else begin
                            st_d.mode = fallback;
                        end
                    end
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode    <= MODE_FREE;
            st_q.ref_sel <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q.mode)
            MODE_ACQ, MODE_NORMAL: freq_out = loop_freq;
            MODE_HOLD:             freq_out = hist_valid ? hist_freq : NOMINAL;
            default:               freq_out = NOMINAL;
        endcase
    end

    assign mode    = st_q.mode;
    assign ref_sel = st_q.ref_sel;
endmodule

// File: rtl/dpll_mode_ctrl_chk.sv
module dpll_mode_ctrl_chk
    import dpll_mode_pkg::*;
#(
    parameter int NUM_REFS = 4,
    parameter int FW       = 16,
    parameter int RW       = $clog2(NUM_REFS)
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_REFS-1:0] ref_qual,
    input logic                phase_lock,
    input logic                force_en,
    input logic [1:0]          force_mode,
    input logic [1:0]          mode,
    input logic [RW-1:0]       ref_sel,
    input logic [FW-1:0]       freq_out,
    input logic                hist_valid
);
    // R2
    free_to_acq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_FREE && (|ref_qual) && !force_en) |=> mode == MODE_ACQ);

    // R3
    acq_ref_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_ACQ && $past(mode) != MODE_ACQ && !$past(force_en))
        |-> ((($past(ref_qual) >> ref_sel) & NUM_REFS'(1)) != '0));

    // R4
    normal_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NORMAL && $past(mode) == MODE_ACQ && !$past(force_en))
        |-> $past(phase_lock, 2));

    // R6
    hold_needs_history_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD && $past(mode) != MODE_HOLD && !$past(force_en))
        |-> $past(hist_valid));

    // R7
    hold_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD && (|ref_qual) && !force_en) |=> mode == MODE_ACQ);

    // R9
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_HOLD && $past(mode) == MODE_HOLD) |-> $stable(freq_out));

    // R10
    force_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_en |=> mode == $past(force_mode));
endmodule

bind dpll_mode_ctrl dpll_mode_ctrl_chk #(.NUM_REFS(NUM_REFS), .FW(FW), .RW(RW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_qual   (ref_qual),
    .phase_lock (phase_lock),
    .force_en   (force_en),
    .force_mode (force_mode),
    .mode       (mode),
    .ref_sel    (ref_sel),
    .freq_out   (freq_out),
    .hist_valid (hist_valid)
);

// File: tb/test_dpll_mode_ctrl.sv
module test_dpll_mode_ctrl;
    localparam int NR   = 4;
    localparam int FW   = 16;
    localparam int L    = 8;
    localparam int S    = 2;
    localparam int HMIN = 8;
    localparam logic [FW-1:0] NOM = 16'h8000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] ref_qual = '0;
    logic          phase_lock = 1'b0;
    logic [FW-1:0] loop_freq = NOM;
    logic          force_en = 1'b0;
    logic [1:0]    force_mode = 2'd0;
    logic [1:0]    mode;
    logic [1:0]    ref_sel;
    logic [FW-1:0] freq_out;

    int checks = 0;
    int fails  = 0;

    // model state
    int            m_mode, m_ref, m_cnt, m_hcnt;
    logic [FW-1:0] m_hist;

    always #5 clk = ~clk;

    dpll_mode_ctrl i_dpll_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .ref_qual(ref_qual), .phase_lock(phase_lock),
        .loop_freq(loop_freq), .force_en(force_en), .force_mode(force_mode),
        .mode(mode), .ref_sel(ref_sel), .freq_out(freq_out)
    );

    function automatic int lowest(input logic [NR-1:0] q);
        for (int i = NR - 1; i >= 0; i--) if (q[i]) lowest = i;
        if (q == '0) lowest = -1;
    endfunction

    function automatic logic [FW-1:0] exp_freq();
        case (m_mode)
            1, 2:    return loop_freq;
            3:       return (m_hcnt >= HMIN) ? m_hist : NOM;
            default: return NOM;
        endcase
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_outputs(input string tag);
        cmp(tag, "mode", int'(mode), m_mode);
        cmp(tag, "ref_sel", int'(ref_sel), m_ref);
        cmp(tag, "freq_out", int'(freq_out), int'(exp_freq()));
    endtask

    task automatic model_reset();
        m_mode = 0; m_ref = 0; m_cnt = 0; m_hcnt = 0; m_hist = NOM;
    endtask

    task automatic model_update();
        int  lo, n_mode, n_ref, n_cnt, n_hcnt, d;
        logic [FW-1:0] n_hist;
        logic any, sel_ok, locked, valid;
        int fb;
        lo     = lowest(ref_qual);
        any    = (ref_qual != '0);
        sel_ok = ref_qual[m_ref];
        locked = (m_cnt >= L);
        valid  = (m_hcnt >= HMIN);
        fb     = valid ? 3 : 0;
        n_cnt  = (m_mode == 1 && sel_ok && phase_lock) ? ((m_cnt < L) ? m_cnt + 1 : m_cnt) : 0;
        n_hist = m_hist;
        n_hcnt = m_hcnt;
        if (m_mode == 2) begin
            if (m_hcnt == 0) n_hist = loop_freq;
            else begin
                d = int'(loop_freq) - int'(m_hist);
                n_hist = FW'(int'(m_hist) + (d >>> S));
            end
            if (m_hcnt < HMIN) n_hcnt = m_hcnt + 1;
        end
        n_mode = m_mode;
        n_ref  = m_ref;
        if (force_en) begin
            n_mode = int'(force_mode);
            if (any) n_ref = lo;
        end else begin
            case (m_mode)
                0, 3: if (any) begin n_mode = 1; n_ref = lo; end
                1: begin
                    if (!any)         n_mode = fb;
                    else if (!sel_ok) n_ref  = lo;
                    else if (locked)  n_mode = 2;
                end
                default: begin
                    if (!sel_ok) begin
                        if (any) begin n_mode = 1; n_ref = lo; end
                        else n_mode = fb;
                    end
                end
            endcase
        end
        m_mode = n_mode; m_ref = n_ref; m_cnt = n_cnt; m_hist = n_hist; m_hcnt = n_hcnt;
    endtask

    // check outputs, apply new inputs, advance model to the next edge
    task automatic step(input logic [NR-1:0] q, input logic pl, input logic [FW-1:0] lf,
                        input logic fe, input logic [1:0] fm, input string tag);
        @(negedge clk);
        check_outputs(tag);
        ref_qual = q; phase_lock = pl; loop_freq = lf; force_en = fe; force_mode = fm;
        model_update();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        ref_qual = '0; phase_lock = 1'b0; loop_freq = NOM; force_en = 1'b0; force_mode = 2'd0;
        model_reset();
        repeat (3) begin
            @(negedge clk);
            check_outputs("R1");
        end
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R2, R3: two references qualified, lowest index (1) chosen
        step(4'b1010, 1'b0, 16'h8100, 1'b0, 2'd0, "R2");
        repeat (4) step(4'b1010, 1'b0, 16'h8100, 1'b0, 2'd0, "R3");
        // R4: interrupted lock run, then a full run
        repeat (5) step(4'b1010, 1'b1, 16'h8100, 1'b0, 2'd0, "R4");
        step(4'b1010, 1'b0, 16'h8100, 1'b0, 2'd0, "R4");
        repeat (14) step(4'b1010, 1'b1, 16'h8100, 1'b0, 2'd0, "R4");
        // R8: history builds in locked mode
        for (int i = 0; i < 20; i++) step(4'b1010, 1'b1, FW'(16'h8100 + i * 37), 1'b0, 2'd0, "R8");
        // R5: selected fails, reference 3 still good
        repeat (3) step(4'b1000, 1'b0, 16'h80f0, 1'b0, 2'd0, "R5");
        repeat (14) step(4'b1000, 1'b1, 16'h80f0, 1'b0, 2'd0, "R5");
        // R6, R9: all lost with valid history -> holdover, live word ignored
        for (int i = 0; i < 10; i++) step(4'b0000, 1'b1, FW'(16'h1234 * (i + 1)), 1'b0, 2'd0, "R9");
        // R7: a reference returns
        repeat (3) step(4'b0100, 1'b0, 16'h8050, 1'b0, 2'd0, "R7");
        // R5: in acquisition, selected fails, other qualified
        repeat (3) step(4'b0001, 1'b1, 16'h8050, 1'b0, 2'd0, "R5");
        // R10: overrides
        repeat (2) step(4'b0001, 1'b0, 16'h8050, 1'b1, 2'd3, "R10");
        repeat (2) step(4'b0000, 1'b0, 16'h8050, 1'b1, 2'd2, "R10");
        repeat (2) step(4'b0110, 1'b0, 16'h8050, 1'b1, 2'd0, "R10");
        repeat (3) step(4'b0110, 1'b0, 16'h8050, 1'b0, 2'd0, "R10");
        // R6: loss before history is valid -> free-run
        do_reset();
        repeat (4) step(4'b0001, 1'b1, 16'h8070, 1'b0, 2'd0, "R6");
        repeat (4) step(4'b0000, 1'b1, 16'h8070, 1'b0, 2'd0, "R6");
        // R10: forced holdover without history gives nominal word
        repeat (3) step(4'b0000, 1'b0, 16'h8070, 1'b1, 2'd3, "R10");
        step(4'b0000, 1'b0, 16'h8070, 1'b0, 2'd0, "R10");
        // random mix
        begin
            logic [NR-1:0] q;
            q = 4'b0011;
            for (int n = 0; n < 3000; n++) begin
                logic fe;
                if ($urandom % 20 == 0) q = ($urandom % 4 == 0) ? '0 : NR'($urandom);
                fe = ($urandom % 60 == 0);
                step(q, ($urandom % 8) != 0, FW'(16'h7f00 + ($urandom % 512)), fe,
                     2'($urandom), "R8");
            end
        end
        @(negedge clk);
        check_outputs("R9");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule